// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Merge

This block keeps one 32-bit control/status word for each of a set of DMA channels and folds their event flags into a single interrupt line. Software reaches the words through a small valid/ready write port that carries a channel index and a data word. Each write can clear event flags by writing ones to them, load the control field, and start or halt the channel. A separate combinational read port returns any channel's word. The channel engine and the request logic report events as one-cycle pulses per channel, and these set sticky flags.

When a write starts a channel, a sequencer sends strobes to the channel engine. The sequencer has three states: `PS_IDLE`, `PS_FETCH` and `PS_KICK`. In `PS_IDLE` the port is ready.
- An accepted write with run set and descriptor fetch enabled takes the transition IDLE→FETCH.
- An accepted write with run set and descriptor fetch disabled takes IDLE→KICK.
- FETCH→KICK and KICK→IDLE are unconditional.
- Any other accepted write stays in IDLE.

`PS_FETCH` drives the descriptor-fetch strobe and `PS_KICK` drives the run strobe. The port is not ready in either state.

Top module: `chan_status_irq`

## Requirements
- R1: After reset every channel reads 0x00000008, with only the stop flag (bit 3) set. The irq output is low, the summary word is zero and wr_ready is high.
- R2: On an accepted write, a 1 in data bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. A 0 leaves it. Bit 4 (request-after-stop) and bit 10 (compare status) are not changed by the data. All stored bits outside 0x0000071F and outside the control field read 0, except that bit 8 follows R10.
- R3: An accepted write loads control bits 31..22 from the data: run 31, no-fetch 30, stop-irq-enable 29, eor-irq-enable 28, eor-jump 27, eor-stop 26, set-compare 25, clear-compare 24, ras-irq-enable 23, mask-run 22.
- R4: A write with data bit 31 set clears the stop flag (bit 3). A write with bits 31 and 22 both clear sets it. A write with only bit 22 set leaves it unchanged.
- R5: Data bit 25 sets the compare status (bit 10). Bit 24 clears it when bit 25 is 0.
- R6: A write with bit 31 set to a valid channel is followed by strobes. If bit 30 is 0, fetch_pulse for that channel is high in the cycle after acceptance and go_pulse in the next cycle. If bit 30 is 1, only go_pulse is high, in the cycle after acceptance. wr_ready is low while a strobe is high.
- R7: Event pulses set bit 0 (bus error), bit 1 (start), bit 2 (end), bit 3 (stop), bit 4 (request-after-stop) and bit 9 (end-of-receive) at the next edge. An event in the same cycle as a write that clears the same bit leaves the bit set.
- R8: A channel's summary bit is (bit3 & bit29) | (bit9 & bit28) | (bit4 & bit23) | bit1 | bit2. The bus error flag does not contribute.
- R9: irq is high exactly when the summary word is nonzero.
- R10: Read bit 8 equals req_active for the addressed channel.
- R11: A write to a channel index at or above NCH changes no channel and gives no strobe. A read at such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Port ready (sequencer idle) |
| wr_chan | input | 5 | Write channel index |
| wr_data | input | 32 | Write data |
| rd_chan | input | 5 | Read channel index |
| rd_data | output | 32 | Status word of rd_chan |
| evt_buserr | input | NCH | Bus error event per channel |
| evt_start | input | NCH | Start event per channel |
| evt_end | input | NCH | End event per channel |
| evt_stop | input | NCH | Stop event per channel |
| evt_ras | input | NCH | Request-after-stop event per channel |
| evt_eor | input | NCH | End-of-receive event per channel |
| req_active | input | NCH | Peripheral request level per channel |
| fetch_pulse | output | NCH | Descriptor fetch strobe |
| go_pulse | output | NCH | Run strobe |
| irq_summary | output | NCH | Per-channel interrupt word |
| irq | output | 1 | Merged interrupt |

## Verification
The checker module watches several properties on every cycle:
- the ordering of the fetch and run strobes, and that the port is not ready while either strobe is high;
- that a run write clears the stop flag and a halt write sets it;
- that an end event always wins against a clear in the same cycle;
- that an ungated start flag always raises the channel's summary bit, and that irq follows the summary word.

Only the bench scenarios can show the rest, by comparing whole status words against a model after random writes and events:
- the exact write-one-to-clear masks and the loading of the control field;
- the compare set/clear precedence;
- the request-pending read bit;
- that writes to out-of-range indices are ignored.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int WORD = 32;
    localparam int IDXW = 5;

    localparam int B_BUSERR  = 0;
    localparam int B_START   = 1;
    localparam int B_END     = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQP    = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MASKRUN = 22;
    localparam int B_RASEN   = 23;
    localparam int B_CLRCMP  = 24;
    localparam int B_SETCMP  = 25;
    localparam int B_EOREN   = 28;
    localparam int B_STOPEN  = 29;
    localparam int B_NOFETCH = 30;
    localparam int B_RUN     = 31;

    localparam logic [WORD-1:0] KEEP_MASK  = 32'h0000_071F;
    localparam logic [WORD-1:0] W1C_MASK   = 32'h0000_0207;
    localparam logic [WORD-1:0] CTRL_MASK  = 32'hFFC0_0000;
    localparam logic [WORD-1:0] RESET_WORD = 32'h0000_0008;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_FETCH = 2'd1,
        PS_KICK  = 2'd2
    } port_state_e;

    // Result of a register write applied to a stored status word.
    function automatic logic [WORD-1:0] apply_write(input logic [WORD-1:0] cur,
                                                    input logic [WORD-1:0] wd);
        logic [WORD-1:0] n;
        n = cur & KEEP_MASK & ~(wd & W1C_MASK);
        n = n | (wd & CTRL_MASK);
        if (wd[B_RUN])
            n[B_STOP] = 1'b0;
        else if (!wd[B_MASKRUN])
            n[B_STOP] = 1'b1;
        if (wd[B_SETCMP])
            n[B_CMP] = 1'b1;
        else if (wd[B_CLRCMP])
            n[B_CMP] = 1'b0;
        n[B_REQP] = 1'b0;
        return n;
    endfunction
endpackage

// File: rtl/csi_chan_reg.sv
module csi_chan_reg
    import csi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WORD-1:0] wr_data,
    input  logic [WORD-1:0] set_bits,
    output logic [WORD-1:0] status
);
    logic [WORD-1:0] next_word;

    always_comb begin
        next_word = wr_en ? apply_write(status, wr_data) : status;
        // Engine events win over a same-cycle clear.
        next_word = next_word | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= RESET_WORD;
        else
            status <= next_word;
    end
endmodule

// File: rtl/csi_port_fsm.sv
module csi_port_fsm
    import csi_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [IDXW-1:0] wr_chan,
    input  logic [WORD-1:0] wr_data,
    output logic            wr_ready,
    output logic [NCH-1:0]  fetch_pulse,
    output logic [NCH-1:0]  go_pulse
);
    port_state_e     state_q, state_d;
    logic [IDXW-1:0] chan_q;
    logic            accept;
    logic            in_range;

    assign in_range = (int'(wr_chan) < NCH);
    assign accept   = wr_valid && (state_q == PS_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (accept && in_range && wr_data[B_RUN])
                    state_d = wr_data[B_NOFETCH] ? PS_KICK : PS_FETCH;
            end
            PS_FETCH: state_d = PS_KICK;
            PS_KICK:  state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                chan_q <= wr_chan;
        end
    end

    always_comb begin
        wr_ready    = (state_q == PS_IDLE);
        fetch_pulse = '0;
        go_pulse    = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan_q == IDXW'(i)) begin
                fetch_pulse[i] = (state_q == PS_FETCH);
                go_pulse[i]    = (state_q == PS_KICK);
            end
        end
    end
endmodule

// File: rtl/csi_irq_merge.sv
module csi_irq_merge
    import csi_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH*WORD-1:0] stat_flat,
    output logic [NCH-1:0]      summary,
    output logic                irq
);
    logic [NCH-1:0] v_stop, v_eor, v_ras, v_start, v_end;

    for (genvar g = 0; g < NCH; g++) begin : g_src
        localparam int BASE = g * WORD;
        assign v_stop[g]  = stat_flat[BASE+B_STOP] & stat_flat[BASE+B_STOPEN];
        assign v_eor[g]   = stat_flat[BASE+B_EOR]  & stat_flat[BASE+B_EOREN];
        assign v_ras[g]   = stat_flat[BASE+B_RAS]  & stat_flat[BASE+B_RASEN];
        assign v_start[g] = stat_flat[BASE+B_START];
        assign v_end[g]   = stat_flat[BASE+B_END];
    end

    assign summary = v_stop | v_eor | v_ras | v_start | v_end;
    assign irq     = |summary;
endmodule

// File: rtl/chan_status_irq.sv
module chan_status_irq
    import csi_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    output logic            wr_ready,
    input  logic [4:0]      wr_chan,
    input  logic [31:0]     wr_data,
    input  logic [4:0]      rd_chan,
    output logic [31:0]     rd_data,
    input  logic [NCH-1:0]  evt_buserr,
    input  logic [NCH-1:0]  evt_start,
    input  logic [NCH-1:0]  evt_end,
    input  logic [NCH-1:0]  evt_stop,
    input  logic [NCH-1:0]  evt_ras,
    input  logic [NCH-1:0]  evt_eor,
    input  logic [NCH-1:0]  req_active,
    output logic [NCH-1:0]  fetch_pulse,
    output logic [NCH-1:0]  go_pulse,
    output logic [NCH-1:0]  irq_summary,
    output logic            irq
);
    logic [NCH*WORD-1:0] stat_flat;
    logic                accept;

    assign accept = wr_valid && wr_ready;

    csi_port_fsm #(.NCH(NCH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_chan     (wr_chan),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .fetch_pulse (fetch_pulse),
        .go_pulse    (go_pulse)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [WORD-1:0] set_bits;
        always_comb begin
            set_bits           = '0;
            set_bits[B_BUSERR] = evt_buserr[g];
            set_bits[B_START]  = evt_start[g];
            set_bits[B_END]    = evt_end[g];
            set_bits[B_STOP]   = evt_stop[g];
            set_bits[B_RAS]    = evt_ras[g];
            set_bits[B_EOR]    = evt_eor[g];
        end
        csi_chan_reg u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (accept && (wr_chan == IDXW'(g))),
            .wr_data  (wr_data),
            .set_bits (set_bits),
            .status   (stat_flat[g*WORD +: WORD])
        );
    end

    csi_irq_merge #(.NCH(NCH)) u_merge (
        .stat_flat (stat_flat),
        .summary   (irq_summary),
        .irq       (irq)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_chan == IDXW'(i)) begin
                rd_data         = stat_flat[i*WORD +: WORD];
                rd_data[B_REQP] = req_active[i];
            end
        end
    end
endmodule

// File: rtl/csi_chk.sv
module csi_chk #(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [4:0]        wr_chan,
    input logic [31:0]       wr_data,
    input logic [NCH-1:0]    evt_end,
    input logic [NCH-1:0]    evt_stop,
    input logic [NCH-1:0]    fetch_pulse,
    input logic [NCH-1:0]    go_pulse,
    input logic [NCH-1:0]    irq_summary,
    input logic              irq,
    input logic [NCH*32-1:0] stat_flat
);
    // R6: a fetch strobe is followed by the run strobe of the same channel.
    a_r6_fetch_then_go: assert property (@(posedge clk) disable iff (!rst_n)
        (|fetch_pulse) |=> (go_pulse == $past(fetch_pulse)));

    // R6: the port is not ready while a strobe is out.
    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fetch_pulse) || (|go_pulse)) |-> !wr_ready);

    a_r6_single_go: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_pulse));

    // R9: a nonzero summary word drives the interrupt line.
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_summary != '0) |-> irq);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R4: run write clears the stop flag
        a_r4_run_clears_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && wr_ready && wr_chan == 5'(g) && wr_data[31] && !evt_stop[g])
            |=> !stat_flat[g*32+3]);
        // R4: halt write sets the stop flag
        a_r4_halt_sets_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && wr_ready && wr_chan == 5'(g) && !wr_data[31] && !wr_data[22])
            |=> stat_flat[g*32+3]);
        // R7: an end event sets its flag even against a clear
        a_r7_end_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_end[g] |=> stat_flat[g*32+2]);
        // R8: the start flag is an ungated source
        a_r8_start_ungated: assert property (@(posedge clk) disable iff (!rst_n)
            stat_flat[g*32+1] |-> irq_summary[g]);
    end
endmodule

bind chan_status_irq csi_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_chan     (wr_chan),
    .wr_data     (wr_data),
    .evt_end     (evt_end),
    .evt_stop    (evt_stop),
    .fetch_pulse (fetch_pulse),
    .go_pulse    (go_pulse),
    .irq_summary (irq_summary),
    .irq         (irq),
    .stat_flat   (stat_flat)
);

// File: tb/chan_status_irq_test.sv
`timescale 1ns/100ps
module chan_status_irq_test;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_valid = 1'b0;
    logic           wr_ready;
    logic [4:0]     wr_chan = '0;
    logic [31:0]    wr_data = '0;
    logic [4:0]     rd_chan = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] evt_buserr = '0, evt_start = '0, evt_end = '0;
    logic [NCH-1:0] evt_stop = '0, evt_ras = '0, evt_eor = '0;
    logic [NCH-1:0] req_active = '0;
    logic [NCH-1:0] fetch_pulse, go_pulse, irq_summary;
    logic           irq;

    int tests = 0;
    int fails = 0;
    logic [31:0] model [NCH];

    always #5 clk = ~clk;

    chan_status_irq #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_chan(wr_chan), .wr_data(wr_data), .rd_chan(rd_chan), .rd_data(rd_data),
        .evt_buserr(evt_buserr), .evt_start(evt_start), .evt_end(evt_end),
        .evt_stop(evt_stop), .evt_ras(evt_ras), .evt_eor(evt_eor),
        .req_active(req_active), .fetch_pulse(fetch_pulse), .go_pulse(go_pulse),
        .irq_summary(irq_summary), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Expected word after a write, built from R2..R5.
    function automatic logic [31:0] exp_write(input logic [31:0] cur, input logic [31:0] d);
        logic [31:0] r;
        r = 32'h0;
        r[0]  = cur[0] & ~d[0];
        r[1]  = cur[1] & ~d[1];
        r[2]  = cur[2] & ~d[2];
        r[9]  = cur[9] & ~d[9];
        r[3]  = cur[3];
        r[4]  = cur[4];
        r[10] = cur[10];
        r[31:22] = d[31:22];
        if (d[31]) r[3] = 1'b0;
        else if (!d[22]) r[3] = 1'b1;
        if (d[25]) r[10] = 1'b1;
        else if (d[24]) r[10] = 1'b0;
        return r;
    endfunction

    function automatic logic exp_src(input logic [31:0] w);
        return (w[3] & w[29]) | (w[9] & w[28]) | (w[4] & w[23]) | w[1] | w[2];
    endfunction

    task automatic check_all(input string tag);
        logic [NCH-1:0] s;
        s = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [31:0] e;
            rd_chan = 5'(i);
            #0.2;
            e = model[i];
            e[8] = req_active[i];
            check(rd_data === e, {tag, " R2 R3 R10 word"}, rd_data, e);
            s[i] = exp_src(model[i]);
        end
        check(irq_summary === s, "R8 summary", 32'(irq_summary), 32'(s));
        check(irq === (s != '0), "R9 irq", 32'(irq), 32'(s != '0));
    endtask

    task automatic wait_ready;
        while (!wr_ready) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus.
    task automatic step(input bit v, input logic [4:0] ch, input logic [31:0] d,
                        input logic [NCH-1:0] eb, es, ee, et, er, eo);
        wait_ready();
        wr_valid = v; wr_chan = ch; wr_data = d;
        evt_buserr = eb; evt_start = es; evt_end = ee;
        evt_stop = et; evt_ras = er; evt_eor = eo;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        evt_buserr = '0; evt_start = '0; evt_end = '0;
        evt_stop = '0; evt_ras = '0; evt_eor = '0;
        if (v && int'(ch) < NCH)
            model[ch] = exp_write(model[ch], d);
        for (int i = 0; i < NCH; i++) begin
            model[i][0] = model[i][0] | eb[i];
            model[i][1] = model[i][1] | es[i];
            model[i][2] = model[i][2] | ee[i];
            model[i][3] = model[i][3] | et[i];
            model[i][4] = model[i][4] | er[i];
            model[i][9] = model[i][9] | eo[i];
        end
        @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] sparse();
        return NCH'($urandom & $urandom & $urandom);
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NCH; i++) model[i] = 32'h0000_0008;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(wr_ready === 1'b1, "R1 ready", 32'(wr_ready), 32'h1);
        for (int i = 0; i < NCH; i++) begin
            rd_chan = 5'(i);
            #0.2;
            check(rd_data === 32'h8, "R1 reset word", rd_data, 32'h8);
        end
        check(irq === 1'b0, "R1 irq", 32'(irq), 32'h0);

        // R6 fetch then go on channel 3
        step(1'b1, 5'd3, 32'h8000_0000, '0, '0, '0, '0, '0, '0);
        check(fetch_pulse === NCH'(8), "R6 fetch strobe", 32'(fetch_pulse), 32'h8);
        check(go_pulse === '0, "R6 no go yet", 32'(go_pulse), 32'h0);
        check(wr_ready === 1'b0, "R6 busy", 32'(wr_ready), 32'h0);
        @(negedge clk);
        check(go_pulse === NCH'(8), "R6 go strobe", 32'(go_pulse), 32'h8);
        check(fetch_pulse === '0, "R6 fetch done", 32'(fetch_pulse), 32'h0);
        @(negedge clk);
        check(wr_ready === 1'b1 && go_pulse === '0, "R6 idle again", 32'(go_pulse), 32'h0);
        check_all("R4 run");

        // R6 no-fetch mode: go straight away on channel 5
        step(1'b1, 5'd5, 32'hC000_0000, '0, '0, '0, '0, '0, '0);
        check(go_pulse === NCH'(32) && fetch_pulse === '0, "R6 direct go",
              32'(go_pulse), 32'h20);

        // R7 event wins over a same-cycle clear on channel 2
        step(1'b1, 5'd2, 32'h0000_0004, '0, NCH'(4), NCH'(4), '0, '0, '0);
        rd_chan = 5'd2;
        #0.2;
        check(rd_data[2] === 1'b1, "R7 event beats clear", rd_data, 32'h4);
        check_all("R7");

        // R5 set and clear compare together: set wins
        step(1'b1, 5'd1, 32'h0340_0000, '0, '0, '0, '0, '0, '0);
        check_all("R5 both");
        step(1'b1, 5'd1, 32'h0140_0000, '0, '0, '0, '0, '0, '0);
        check_all("R5 clear");

        // R11 out-of-range write: no change, no strobe, read 0
        step(1'b1, 5'd20, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, '0);
        check(fetch_pulse === '0 && go_pulse === '0 && wr_ready === 1'b1,
              "R11 no strobe", 32'(go_pulse), 32'h0);
        check_all("R11");
        rd_chan = 5'd20;
        #0.2;
        check(rd_data === 32'h0, "R11 read zero", rd_data, 32'h0);

        // R8 gated sources: stop flag with enable, then without
        step(1'b1, 5'd6, 32'h2000_0000, '0, '0, '0, '0, '0, '0);
        check_all("R8 stop gated");
        step(1'b1, 5'd6, 32'h0000_0000, NCH'(64), '0, '0, '0, '0, '0);
        check_all("R8 no enable, buserr");

        // Random mix (R2 R3 R4 R5 R7 R8 R9 R10)
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            logic [4:0]  ch;
            d  = $urandom;
            ch = 5'($urandom_range(0, NCH + 1));
            req_active = NCH'($urandom);
            step(($urandom % 4) != 0, ch, d,
                 sparse(), sparse(), sparse(), sparse(), sparse(), sparse());
            wait_ready();
            check_all("random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule